// File: doc/BRIEF.md
# Interrupt Table Register and Descriptor Lookup

This block owns the register that locates the interrupt descriptor table in memory: a 32-bit linear base address and a 16-bit byte limit. Software-side requests load or read that register through a 48-bit image. The limit sits in bits 15:0 and the base in bits 47:16, which is the little-endian 6-byte layout. A load is honoured only at the most privileged level. A read of the register is allowed at every level.

Interrupt logic hands the block an 8-bit vector. The block scales the vector by eight to get the entry offset. It checks that the whole 8-byte entry lies within the limit. If it does, the block reads the entry as two 32-bit words from a simple memory port and returns the 64-bit descriptor. If it does not, the block reports a fault and touches memory not at all. Vector 0 is an ordinary entry at offset 0.

Top module: `intr_table_unit`

## Requirements
- R1: After reset the register holds base 0x00000000 and limit 0x03FF.
- R2: A register request with `reg_req_load`=1 and `reg_cpl`=0 copies `reg_wdata[15:0]` into the limit and `reg_wdata[47:16]` into the base. `reg_rsp_valid`=1 and `reg_rsp_fault`=0 follow in the next cycle.
- R3: A load request with `reg_cpl` not 0 answers in the next cycle with `reg_rsp_fault`=1 and leaves base and limit unchanged.
- R4: A register request with `reg_req_load`=0, at any `reg_cpl`, answers in the next cycle with `reg_rsp_fault`=0. `reg_rdata` carries the limit in bits 15:0 and the base in bits 47:16.
- R5: An accepted lookup reads the low descriptor word at base + vector×8, computed modulo 2^32. It then reads the high word at that address + 4, also modulo 2^32.
- R6: A lookup whose vector×8 + 7 exceeds the limit ends with `lk_done`=1 and `lk_fault`=1 in the cycle after acceptance. It issues no memory read, and `lk_desc` reads 0.
- R7: Vector 0 is a valid entry at offset 0. It succeeds whenever the limit is at least 7.
- R8: A successful lookup raises `lk_done` for one cycle, the cycle after the second read is acknowledged. In that cycle `lk_fault`=0 and `lk_desc` = {high word, low word}.
- R9: `lk_ready` is low from the cycle after a lookup is accepted until the cycle after `lk_done`, so only one lookup is in flight. `lk_done` never lasts longer than one cycle.
- R10: `mem_req` stays high with `mem_addr` unchanged until `mem_ack` is seen. Read data is taken in the cycle of `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req_valid | input | 1 | Register request strobe |
| reg_req_load | input | 1 | 1 = load register, 0 = read register |
| reg_cpl | input | 2 | Current privilege level of the requester |
| reg_wdata | input | 48 | Image to load: limit [15:0], base [47:16] |
| reg_rsp_valid | output | 1 | Register response strobe |
| reg_rsp_fault | output | 1 | Privilege fault on a load |
| reg_rdata | output | 48 | Image returned by a read request |
| lk_valid | input | 1 | Lookup request valid |
| lk_vector | input | 8 | Interrupt or exception vector |
| lk_ready | output | 1 | Lookup request accepted when high with lk_valid |
| lk_done | output | 1 | Lookup finished, one-cycle strobe |
| lk_fault | output | 1 | Entry outside the limit |
| lk_desc | output | 64 | Fetched descriptor |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
The lookup is swept over all 256 vectors under three register settings. The reset base and limit put the pass/fault boundary between vectors 127 and 128. A base just below 2^32 with the largest needed limit makes the second word and later entries wrap to low addresses. Tiny limits of 0, 14 and 15 decide whether entries 0 and 1 fit by exactly one byte. The memory returns an address-derived pattern and acknowledges only every other cycle, so a swapped word order, a wrong address step or data taken before the acknowledge all show up. Register loads are tried at every privilege level, and each is followed by a read-back that tells a silent corruption from a correct refusal.

// File: rtl/intr_table_pkg.sv
package intr_table_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_LOW  = 2'd1,
        FS_HIGH = 2'd2,
        FS_DONE = 2'd3
    } fetch_state_e;

endpackage

// File: rtl/itab_register.sv
module itab_register #(
    parameter int ADDR_W    = 32,
    parameter int LIMIT_W   = 16,
    parameter int CPL_W     = 2,
    parameter logic [LIMIT_W-1:0] RST_LIMIT = 16'h03FF,
    localparam int IMG_W    = ADDR_W + LIMIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_load,
    input  logic [CPL_W-1:0]   req_cpl,
    input  logic [IMG_W-1:0]   req_image,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [IMG_W-1:0]   rsp_image,
    output logic [ADDR_W-1:0]  base,
    output logic [LIMIT_W-1:0] limit
);

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [LIMIT_W-1:0] limit;
        logic               rsp_valid;
        logic               rsp_fault;
        logic [IMG_W-1:0]   rsp_image;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_fault = 1'b0;
        if (req_valid) begin
            if (req_load) begin
                if (req_cpl == '0) begin
                    st_d.limit = req_image[LIMIT_W-1:0];
                    st_d.base  = req_image[IMG_W-1:LIMIT_W];
                end else begin
                    st_d.rsp_fault = 1'b1;
                end
            end else begin
                st_d.rsp_image = {st_q.base, st_q.limit};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.base      <= '0;
            st_q.limit     <= RST_LIMIT;
            st_q.rsp_valid <= 1'b0;
            st_q.rsp_fault <= 1'b0;
            st_q.rsp_image <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_fault = st_q.rsp_fault;
    assign rsp_image = st_q.rsp_image;
    assign base      = st_q.base;
    assign limit     = st_q.limit;

endmodule

// File: rtl/itab_bounds.sv
module itab_bounds #(
    parameter int ADDR_W      = 32,
    parameter int LIMIT_W     = 16,
    parameter int VEC_W       = 8,
    parameter int ENTRY_SHIFT = 3,
    localparam int OFF_W      = VEC_W + ENTRY_SHIFT,
    localparam int ENTRY_B    = 1 << ENTRY_SHIFT
) (
    input  logic [VEC_W-1:0]   vector,
    input  logic [ADDR_W-1:0]  base,
    input  logic [LIMIT_W-1:0] limit,
    output logic [ADDR_W-1:0]  entry_addr,
    output logic               in_range
);

    logic [OFF_W-1:0]   offset;
    logic [LIMIT_W:0]   last_byte;

    always_comb begin
        offset     = {vector, {ENTRY_SHIFT{1'b0}}};
        last_byte  = (LIMIT_W+1)'(offset) + (LIMIT_W+1)'(ENTRY_B - 1);
        in_range   = (last_byte <= {1'b0, limit});
        entry_addr = base + ADDR_W'(offset);
    end

endmodule

// File: rtl/itab_fetch.sv
module itab_fetch
    import intr_table_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    localparam int DESC_W = 2 * DATA_W,
    localparam int STEP   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_range,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              idle,
    output logic              done,
    output logic              fault,
    output logic [DESC_W-1:0] desc,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    typedef struct packed {
        fetch_state_e      st;
        logic [ADDR_W-1:0] addr;
        logic [DESC_W-1:0] desc;
        logic              fault;
    } fetch_t;

    fetch_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.st)
            FS_IDLE: begin
                if (start) begin
                    f_d.desc = '0;
                    if (in_range) begin
                        f_d.st    = FS_LOW;
                        f_d.addr  = start_addr;
                        f_d.fault = 1'b0;
                    end else begin
                        f_d.st    = FS_DONE;
                        f_d.fault = 1'b1;
                    end
                end
            end
            FS_LOW: begin
                if (mem_ack) begin
                    f_d.desc[DATA_W-1:0] = mem_rdata;
                    f_d.addr = f_q.addr + ADDR_W'(STEP);
                    f_d.st   = FS_HIGH;
                end
            end
            FS_HIGH: begin
                if (mem_ack) begin
                    f_d.desc[DESC_W-1:DATA_W] = mem_rdata;
                    f_d.st = FS_DONE;
                end
            end
            default: f_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '{st: FS_IDLE, addr: '0, desc: '0, fault: 1'b0};
        end else begin
            f_q <= f_d;
        end
    end

    assign idle     = (f_q.st == FS_IDLE);
    assign done     = (f_q.st == FS_DONE);
    assign fault    = done & f_q.fault;
    assign desc     = f_q.desc;
    assign mem_req  = (f_q.st == FS_LOW) || (f_q.st == FS_HIGH);
    assign mem_addr = f_q.addr;

endmodule

// File: rtl/intr_table_unit.sv
module intr_table_unit #(
    parameter int ADDR_W      = 32,
    parameter int LIMIT_W     = 16,
    parameter int VEC_W       = 8,
    parameter int ENTRY_SHIFT = 3,
    parameter int CPL_W       = 2,
    parameter int DATA_W      = 32,
    parameter logic [LIMIT_W-1:0] RST_LIMIT = 16'h03FF,
    localparam int IMG_W      = ADDR_W + LIMIT_W,
    localparam int DESC_W     = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req_valid,
    input  logic              reg_req_load,
    input  logic [CPL_W-1:0]  reg_cpl,
    input  logic [IMG_W-1:0]  reg_wdata,
    output logic              reg_rsp_valid,
    output logic              reg_rsp_fault,
    output logic [IMG_W-1:0]  reg_rdata,
    input  logic              lk_valid,
    input  logic [VEC_W-1:0]  lk_vector,
    output logic              lk_ready,
    output logic              lk_done,
    output logic              lk_fault,
    output logic [DESC_W-1:0] lk_desc,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic [ADDR_W-1:0]  tbl_base;
    logic [LIMIT_W-1:0] tbl_limit;
    logic [ADDR_W-1:0]  entry_addr;
    logic               entry_ok;
    logic               fetch_idle;

    itab_register #(
        .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .CPL_W(CPL_W), .RST_LIMIT(RST_LIMIT)
    ) u_reg (
        .clk(clk), .rst_n(rst_n),
        .req_valid(reg_req_valid), .req_load(reg_req_load),
        .req_cpl(reg_cpl), .req_image(reg_wdata),
        .rsp_valid(reg_rsp_valid), .rsp_fault(reg_rsp_fault),
        .rsp_image(reg_rdata),
        .base(tbl_base), .limit(tbl_limit)
    );

    itab_bounds #(
        .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .VEC_W(VEC_W), .ENTRY_SHIFT(ENTRY_SHIFT)
    ) u_bounds (
        .vector(lk_vector), .base(tbl_base), .limit(tbl_limit),
        .entry_addr(entry_addr), .in_range(entry_ok)
    );

    itab_fetch #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .start(lk_valid), .in_range(entry_ok), .start_addr(entry_addr),
        .idle(fetch_idle), .done(lk_done), .fault(lk_fault), .desc(lk_desc),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    assign lk_ready = fetch_idle;

endmodule

// File: rtl/intr_table_checker.sv
module intr_table_checker #(
    parameter int ADDR_W = 32,
    parameter int CPL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_req_valid,
    input logic              reg_req_load,
    input logic [CPL_W-1:0]  reg_cpl,
    input logic              reg_rsp_valid,
    input logic              reg_rsp_fault,
    input logic              lk_ready,
    input logic              lk_done,
    input logic              lk_fault,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req_valid |=> reg_rsp_valid); // R2

    AST_LOW_PRIV_LOAD_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req_valid && reg_req_load && (reg_cpl != '0) |=> reg_rsp_fault); // R3

    AST_READ_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req_valid && !reg_req_load |=> !reg_rsp_fault); // R4

    AST_FAULT_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done && lk_fault |-> !mem_req); // R6

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || lk_done) |-> !lk_ready); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |=> !lk_done); // R9

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R10

endmodule

bind intr_table_unit intr_table_checker #(.ADDR_W(ADDR_W), .CPL_W(CPL_W)) u_checker (
    .clk(clk), .rst_n(rst_n),
    .reg_req_valid(reg_req_valid), .reg_req_load(reg_req_load), .reg_cpl(reg_cpl),
    .reg_rsp_valid(reg_rsp_valid), .reg_rsp_fault(reg_rsp_fault),
    .lk_ready(lk_ready), .lk_done(lk_done), .lk_fault(lk_fault),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/test_intr_table_unit.sv
module test_intr_table_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req_valid = 1'b0;
    logic        reg_req_load = 1'b0;
    logic [1:0]  reg_cpl = '0;
    logic [47:0] reg_wdata = '0;
    logic        reg_rsp_valid, reg_rsp_fault;
    logic [47:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [7:0]  lk_vector = '0;
    logic        lk_ready, lk_done, lk_fault;
    logic [63:0] lk_desc;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int rd_cnt = 0;
    logic [31:0] rd_addr [4];
    logic tog = 1'b0;

    always #2 clk = ~clk;

    intr_table_unit i_intr_table_unit (.*);

    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        return (a * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
    endfunction

    // memory model: acknowledges every other cycle, records addresses
    always @(negedge clk) begin
        tog = ~tog;
        if (mem_req && tog) begin
            mem_ack   = 1'b1;
            mem_rdata = mem_fn(mem_addr);
            rd_addr[rd_cnt % 4] = mem_addr;
            rd_cnt++;
        end else begin
            mem_ack   = 1'b0;
            mem_rdata = '0;
        end
    end

    task automatic check(input logic ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_op(input logic ld, input logic [1:0] cpl, input logic [47:0] wd,
                          output logic vld, output logic flt, output logic [47:0] img);
        @(negedge clk);
        reg_req_valid = 1'b1; reg_req_load = ld; reg_cpl = cpl; reg_wdata = wd;
        @(negedge clk);
        reg_req_valid = 1'b0;
        vld = reg_rsp_valid; flt = reg_rsp_fault; img = reg_rdata;
    endtask

    task automatic read_reg(input logic [1:0] cpl, input logic [47:0] exp, input string req);
        logic v, f; logic [47:0] img;
        reg_op(1'b0, cpl, '0, v, f, img);
        check(v && !f && img == exp, req, {15'd0, v, f, img}, {16'h8000, exp});
    endtask

    task automatic load_reg(input logic [1:0] cpl, input logic [47:0] wd,
                            input logic exp_fault, input string req);
        logic v, f; logic [47:0] img;
        reg_op(1'b1, cpl, wd, v, f, img);
        check(v && f == exp_fault, req, {62'd0, v, f}, {62'd0, 1'b1, exp_fault});
    endtask

    task automatic lookup(input logic [7:0] v, input logic [31:0] base,
                          input logic [15:0] limit, input string req);
        logic busy_ok = 1'b1;
        logic exp_f;
        logic [31:0] a0;
        logic [63:0] exp_d;
        int exp_n;
        @(negedge clk);
        rd_cnt = 0;
        lk_valid = 1'b1; lk_vector = v;
        while (!lk_ready) @(negedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
        while (!lk_done) begin
            if (lk_ready) busy_ok = 1'b0;
            @(negedge clk);
        end
        exp_f = ({5'd0, v, 3'd0} + 16'd7) > limit;
        a0    = base + {21'd0, v, 3'd0};
        exp_d = exp_f ? 64'd0 : {mem_fn(a0 + 32'd4), mem_fn(a0)};
        exp_n = exp_f ? 0 : 2;
        check(lk_fault == exp_f && lk_desc == exp_d && rd_cnt == exp_n,
              req, {lk_fault, 7'(rd_cnt), lk_desc[55:0]}, {exp_f, 7'(exp_n), exp_d[55:0]});
        if (!exp_f)
            check(rd_addr[0] == a0 && rd_addr[1] == a0 + 32'd4, "R5 address order",
                  {rd_addr[0], rd_addr[1]}, {a0, a0 + 32'd4});
        check(busy_ok && !lk_ready, "R9 ready low while busy", {63'd0, busy_ok}, 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R4 read at lowest privilege
        read_reg(2'd3, {32'h0, 16'h03FF}, "R1 R4 reset image");
        // R5 R6 R8 sweep with reset register: boundary 127/128
        for (int v = 0; v < 256; v++)
            lookup(8'(v), 32'h0, 16'h03FF, "R6 R8 reset sweep");
        // R3 privilege refusal at every nonzero level
        for (int c = 1; c < 4; c++) begin
            load_reg(2'(c), 48'hDEAD_BEEF_1234, 1'b1, "R3 load refused");
            read_reg(2'(c), {32'h0, 16'h03FF}, "R3 register unchanged");
        end
        // R2 load at level 0, near-top base to force wraparound
        load_reg(2'd0, {32'hFFFF_FFF0, 16'h07FF}, 1'b0, "R2 load accepted");
        read_reg(2'd0, {32'hFFFF_FFF0, 16'h07FF}, "R2 R4 image after load");
        for (int v = 0; v < 256; v++)
            lookup(8'(v), 32'hFFFF_FFF0, 16'h07FF, "R5 R8 wrap sweep");
        // R7 vector 0 at offset 0, tight limits
        load_reg(2'd0, {32'h0000_1000, 16'h0000}, 1'b0, "R2 load limit 0");
        lookup(8'd0, 32'h0000_1000, 16'h0000, "R6 R7 vector 0 limit 0 faults");
        load_reg(2'd0, {32'h0000_1000, 16'h000E}, 1'b0, "R2 load limit 14");
        lookup(8'd0, 32'h0000_1000, 16'h000E, "R7 vector 0 usable");
        lookup(8'd1, 32'h0000_1000, 16'h000E, "R6 vector 1 one byte short");
        load_reg(2'd0, {32'h0000_1000, 16'h000F}, 1'b0, "R2 load limit 15");
        lookup(8'd1, 32'h0000_1000, 16'h000F, "R6 vector 1 fits exactly");
        lookup(8'd2, 32'h0000_1000, 16'h000F, "R6 vector 2 outside");
        lookup(8'd255, 32'h0000_1000, 16'h000F, "R6 top vector outside");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule